// File: doc/BRIEF.md
# Synthesizer Divider Configuration Port

This block keeps the three settings that steer a frequency synthesizer: a 7-bit feedback modulus, a 2-bit output-divider code and a 3-bit test-select code. Two ports can write the settings. The first is a set of parallel pins with a load strobe. The second is a 3-wire serial port with a data line, a shift clock and a load strobe. The active settings are always present on the outputs. A further output gives the bit at the top of the serial shift register, so a chain of such registers can be observed.

All strobes and data inputs come in from off-chip, asynchronous to the system clock. Each one passes through a synchroniser of its own before it is used. The latch behaviour is modelled at the system clock. A port that is "open" writes the shared settings register on every system clock while its strobe sits at its open level. When the strobe leaves that level, the register keeps the last value written. The parallel port is open while its strobe is low. The serial port is open while its strobe is high. When both ports are open, the parallel port wins. The parallel port cannot write the test code: while the parallel strobe is low, the test code is held at zero.

Top module: `synth_cfg_port`

## Requirements
- R1: While reset is asserted, and after its release with the parallel strobe high and the serial strobe low, the modulus, the divider code, the test code and the serial output are all zero.
- R2: Each rising edge of the serial clock shifts the 12-bit register by one place and puts the serial data bit in at bit 0. The serial output always shows register bit 11, which holds the first bit of the last 12 shifted.
- R3: A serial frame is shifted in with the test code first, then the divider code, then the modulus, most significant bit first in each field. After 12 shifts, register bits 11:9 hold the test code, bits 8:7 the divider code and bits 6:0 the modulus.
- R4: While the serial strobe is high and the parallel strobe is high, the outputs follow the shift register contents, including shifts made during that time.
- R5: When the serial strobe falls, the outputs keep the values they held. Later shifts do not change them.
- R6: While the parallel strobe is low, the modulus and divider-code outputs follow the parallel pins.
- R7: When the parallel strobe rises, the outputs keep the values the pins had. Later pin changes have no effect while the strobe stays high.
- R8: While the parallel strobe is low, a high serial strobe has no effect: the outputs show the parallel pins.
- R9: While the parallel strobe is low, the test code output is 000, whatever was loaded serially before.
- R10: A serial load pulse that starts and ends while the parallel strobe is low leaves no trace: after the parallel strobe rises, the outputs hold the captured parallel values.
- R11: A change on a strobe or data input reaches the outputs after the synchroniser depth plus one system clocks. With the default depth of two, this is three clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_ld_i | input | 1 | Parallel load strobe; the parallel port is open while it is low |
| par_m_i | input | 7 | Parallel modulus pins |
| par_n_i | input | 2 | Parallel divider-code pins |
| ser_clk_i | input | 1 | Serial shift clock; the register shifts on its rising edge |
| ser_dat_i | input | 1 | Serial data line |
| ser_ld_i | input | 1 | Serial load strobe; the serial port is open while it is high |
| m_o | output | 7 | Active feedback modulus |
| n_o | output | 2 | Active output-divider code |
| t_o | output | 3 | Active test-select code |
| ser_out_o | output | 1 | Shift register bit 11 |

## Verification
The bench targets the points where the two ports meet. It holds the serial strobe high while the parallel strobe is low and checks that the test code stays zero. A design with the priority reversed would show the serial frame instead, or let a nonzero test code through. The bench sends a serial load pulse entirely inside a parallel-open window, then raises the parallel strobe. A design that remembered the serial request would jump to the serial frame at that point. The bench also shifts with the serial strobe held high and again after it has fallen. A design that captured on the wrong strobe edge would miss the live update in the first case, or drift with the shifts in the second. Frames with distinct values in every field show any mistake in the field order.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;

  localparam int M_W  = 7;
  localparam int N_W  = 2;
  localparam int T_W  = 3;
  localparam int SR_W = T_W + N_W + M_W;

  // Field order follows the serial stream: test code first, modulus last.
  typedef struct packed {
    logic [T_W-1:0] t;
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } cfg_t;

  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_PAR  = 2'd1,
    SRC_SER  = 2'd2
  } cfg_src_e;

endpackage

// File: rtl/scfg_rst_sync.sv
module scfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/scfg_sync.sv
module scfg_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic [W-1:0] stage_d;
      if (g == 0) begin : g_first
        always_comb stage_d = d_i;
      end else begin : g_rest
        always_comb stage_d = stage_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[g] <= RST_VAL;
        end else begin
          stage_q[g] <= stage_d;
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/scfg_shreg.sv
module scfg_shreg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] q_o
);

  logic [W-1:0] sr_q;
  logic [W-1:0] sr_d;

  always_comb begin
    sr_d = sr_q;
    if (shift_en) begin
      sr_d = {sr_q[W-2:0], din};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else begin
      sr_q <= sr_d;
    end
  end

  assign q_o = sr_q;

endmodule

// File: rtl/scfg_latch_ctl.sv
module scfg_latch_ctl
  import synth_cfg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic par_ld,
  input  logic ser_ld,
  input  cfg_t par_cfg,
  input  cfg_t ser_cfg,
  output cfg_t cfg_o
);

  cfg_src_e src;
  cfg_t     cfg_q;
  cfg_t     cfg_d;
  logic     cfg_en;

  // Parallel port open while its strobe is low; it outranks the serial port.
  always_comb begin
    if (!par_ld) begin
      src = SRC_PAR;
    end else if (ser_ld) begin
      src = SRC_SER;
    end else begin
      src = SRC_HOLD;
    end
  end

  always_comb begin
    cfg_en = (src != SRC_HOLD);
    cfg_d  = cfg_q;
    unique case (src)
      SRC_PAR: begin
        cfg_d.m = par_cfg.m;
        cfg_d.n = par_cfg.n;
        cfg_d.t = '0;
      end
      SRC_SER:  cfg_d = ser_cfg;
      default:  cfg_d = cfg_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_en) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg_o = cfg_q;

endmodule

// File: rtl/synth_cfg_port.sv
module synth_cfg_port
  import synth_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           par_ld_i,
  input  logic [M_W-1:0] par_m_i,
  input  logic [N_W-1:0] par_n_i,
  input  logic           ser_clk_i,
  input  logic           ser_dat_i,
  input  logic           ser_ld_i,
  output logic [M_W-1:0] m_o,
  output logic [N_W-1:0] n_o,
  output logic [T_W-1:0] t_o,
  output logic           ser_out_o
);

  localparam int IN_W = M_W + N_W + 4;
  // Bit order of the bundle: par_ld, ser_ld, sclk, sdat, n, m.
  localparam logic [IN_W-1:0] IN_RST = {1'b1, {(IN_W-1){1'b0}}};

  logic              rst_sync_n;
  logic [IN_W-1:0]   in_raw;
  logic [IN_W-1:0]   in_s;
  logic              par_ld_s;
  logic              ser_ld_s;
  logic              sclk_s;
  logic              sdat_s;
  logic [N_W-1:0]    pn_s;
  logic [M_W-1:0]    pm_s;
  logic              sclk_q;
  logic              sclk_rise;
  logic [SR_W-1:0]   sr_q;
  cfg_t              par_cfg;
  cfg_t              ser_cfg;
  cfg_t              cfg;

  scfg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign in_raw = {par_ld_i, ser_ld_i, ser_clk_i, ser_dat_i, par_n_i, par_m_i};

  // One synchroniser for the whole bundle keeps data aligned with strobes.
  scfg_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(IN_RST)) u_in_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   (in_raw),
    .q_o   (in_s)
  );

  assign {par_ld_s, ser_ld_s, sclk_s, sdat_s, pn_s, pm_s} = in_s;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sclk_q <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_q;

  scfg_shreg #(.W(SR_W)) u_shreg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .shift_en (sclk_rise),
    .din      (sdat_s),
    .q_o      (sr_q)
  );

  assign par_cfg = '{t: '0, n: pn_s, m: pm_s};
  assign ser_cfg = cfg_t'(sr_q);

  scfg_latch_ctl u_latch (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .par_ld  (par_ld_s),
    .ser_ld  (ser_ld_s),
    .par_cfg (par_cfg),
    .ser_cfg (ser_cfg),
    .cfg_o   (cfg)
  );

  assign m_o       = cfg.m;
  assign n_o       = cfg.n;
  assign t_o       = cfg.t;
  assign ser_out_o = sr_q[SR_W-1];

endmodule

// File: rtl/synth_cfg_chk.sv
module synth_cfg_chk
  import synth_cfg_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            par_ld,
  input logic            ser_ld,
  input logic            sclk_rise,
  input logic            sdat,
  input logic [M_W-1:0]  pm,
  input logic [N_W-1:0]  pn,
  input logic [SR_W-1:0] sr,
  input logic [M_W-1:0]  m,
  input logic [N_W-1:0]  n,
  input logic [T_W-1:0]  t
);

  // R2
  shift_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_rise |=> $stable(sr));

  // R2
  shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> (sr[0] == $past(sdat)));

  // R9
  t_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !par_ld |=> (t == '0));

  // R8
  par_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !par_ld |=> (m == $past(pm)) && (n == $past(pn)));

  // R4
  ser_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (par_ld && ser_ld) |=> (m == $past(sr[M_W-1:0])) && (t == $past(sr[SR_W-1 -: T_W])));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (par_ld && !ser_ld) |=> $stable(m) && $stable(n) && $stable(t));

endmodule

bind synth_cfg_port synth_cfg_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .par_ld    (par_ld_s),
  .ser_ld    (ser_ld_s),
  .sclk_rise (sclk_rise),
  .sdat      (sdat_s),
  .pm        (pm_s),
  .pn        (pn_s),
  .sr        (sr_q),
  .m         (m_o),
  .n         (n_o),
  .t         (t_o)
);

// File: tb/synth_cfg_port_bench.sv
module synth_cfg_port_bench;

  logic       clk;
  logic       rst_n;
  logic       par_ld;
  logic [6:0] par_m;
  logic [1:0] par_n;
  logic       ser_clk;
  logic       ser_dat;
  logic       ser_ld;
  logic [6:0] m_o;
  logic [1:0] n_o;
  logic [2:0] t_o;
  logic       ser_out;

  int tests;
  int fails;
  int cyc;
  bit done;

  // {frame[11:0], t[2:0], n[1:0], m[6:0]}
  localparam logic [23:0] VEC [4] = '{
    {12'hB30, 3'b101, 2'b10, 7'h30},
    {12'h4FF, 3'b010, 2'b01, 7'h7F},
    {12'hF81, 3'b111, 2'b11, 7'h01},
    {12'h055, 3'b000, 2'b00, 7'h55}
  };

  synth_cfg_port u_synth_cfg_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .par_ld_i  (par_ld),
    .par_m_i   (par_m),
    .par_n_i   (par_n),
    .ser_clk_i (ser_clk),
    .ser_dat_i (ser_dat),
    .ser_ld_i  (ser_ld),
    .m_o       (m_o),
    .n_o       (n_o),
    .t_o       (t_o),
    .ser_out_o (ser_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000 && !done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
    end
  end

  task automatic wait_clk(input int k);
    repeat (k) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_cfg(input string tag, input logic [2:0] t, input logic [1:0] n, input logic [6:0] m);
    chk(tag, {20'd0, t_o, n_o, m_o}, {20'd0, t, n, m});
  endtask

  task automatic send_bit(input logic b);
    ser_dat = b;
    wait_clk(4);
    ser_clk = 1'b1;
    wait_clk(4);
    ser_clk = 1'b0;
    wait_clk(4);
  endtask

  task automatic send_frame(input logic [11:0] f);
    for (int i = 11; i >= 0; i--) send_bit(f[i]);
  endtask

  task automatic pulse_sload();
    ser_ld = 1'b1;
    wait_clk(6);
    ser_ld = 1'b0;
    wait_clk(6);
  endtask

  initial begin
    tests = 0; fails = 0; cyc = 0; done = 1'b0;
    rst_n = 1'b0; par_ld = 1'b1; par_m = 7'h5A; par_n = 2'b11;
    ser_clk = 1'b0; ser_dat = 1'b0; ser_ld = 1'b0;
    wait_clk(3);
    chk_cfg("R1 in reset", 3'b000, 2'b00, 7'h00);
    chk("R1 ser_out in reset", {31'd0, ser_out}, 32'd0);
    rst_n = 1'b1;
    wait_clk(8);
    chk_cfg("R1 after release", 3'b000, 2'b00, 7'h00);
    chk("R1 ser_out after release", {31'd0, ser_out}, 32'd0);

    // Table walk: serial frames with R3 field order, loaded by a strobe pulse.
    for (int v = 0; v < 4; v++) begin
      send_frame(VEC[v][23:12]);
      chk("R2 ser_out is first bit", {31'd0, ser_out}, {31'd0, VEC[v][23]});
      pulse_sload();
      chk_cfg("R3 frame fields", VEC[v][11:9], VEC[v][8:7], VEC[v][6:0]);
    end

    // R11: latency of a parallel change is three clocks.
    par_m = 7'h21; par_n = 2'b10;
    @(negedge clk);
    par_ld = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R11 no change after two clocks", {25'd0, m_o}, 32'h55);
    @(posedge clk);
    @(negedge clk);
    chk("R11 change after three clocks", {25'd0, m_o}, 32'h21);

    // R6 / R9: transparent parallel port, test code zero.
    wait_clk(4);
    chk_cfg("R6 follow pins", 3'b000, 2'b10, 7'h21);
    par_m = 7'h33; par_n = 2'b01;
    wait_clk(5);
    chk_cfg("R6 follow new pins", 3'b000, 2'b01, 7'h33);

    // R7: capture on rising edge.
    par_ld = 1'b1;
    wait_clk(5);
    par_m = 7'h0F; par_n = 2'b00;
    wait_clk(6);
    chk_cfg("R7 hold after rise", 3'b000, 2'b01, 7'h33);

    // Serial load T=111 frame so T is nonzero.
    send_frame(12'hF81);
    pulse_sload();
    chk_cfg("R3 load before priority test", 3'b111, 2'b11, 7'h01);

    // R8 / R9: parallel low with serial strobe high.
    par_m = 7'h44; par_n = 2'b10;
    par_ld = 1'b0;
    ser_ld = 1'b1;
    wait_clk(6);
    chk_cfg("R8 parallel wins", 3'b000, 2'b10, 7'h44);
    chk("R9 test code zero", {29'd0, t_o}, 32'd0);
    ser_ld = 1'b0;
    wait_clk(6);

    // R10: serial pulse inside the parallel-open window leaves no trace.
    send_frame(12'hB30);
    pulse_sload();
    par_ld = 1'b1;
    wait_clk(6);
    chk_cfg("R10 no serial trace", 3'b000, 2'b10, 7'h44);

    // R4: transparency while serial strobe high (register holds B30).
    ser_ld = 1'b1;
    wait_clk(6);
    chk_cfg("R4 open shows register", 3'b101, 2'b10, 7'h30);
    send_bit(1'b1);
    chk_cfg("R4 live shift", 3'b011, 2'b00, 7'h61);

    // R5: falling edge holds, later shifts ignored.
    ser_ld = 1'b0;
    wait_clk(6);
    send_bit(1'b0);
    send_bit(1'b1);
    chk_cfg("R5 hold after fall", 3'b011, 2'b00, 7'h61);
    chk("R2 ser_out after shifts", {31'd0, ser_out}, 32'd1);

    summary();
  end

endmodule